// File: doc/BRIEF.md
# Bitwise Bus Arbitration Unit

This unit resolves collisions on a single-wire, wired-AND bus without corrupting the winner's frame. While the identifier byte of a frame goes out, it checks every bit it drives against the level read back from the line. A node that sends a recessive one but reads a dominant zero has lost. That node drops its driver enable for the rest of the identifier but keeps assembling received bytes.

A second stage works on whole bytes. At every byte boundary of an active frame, identifier included, it compares the byte assembled from the transmitted stream with the byte assembled from the bus. A mismatch ends the frame. After any loss the unit holds off the next attempt until it sees an inter-frame space, meaning the bus stays recessive for a set number of bit strobes. A new frame may start only in normal mode, when no loss is pending and no reception is under way.

Line coding, bit timing and byte framing are done outside the unit. The unit sees one strobe per bit, a marker on the last bit of each byte, and a marker on the last byte of a frame.

Top module: `arb_unit`

## Requirements
- R1: After reset `drv_en_o`, `lost_o` and `rx_vld_o` are 0. With `normal_i`=1 and `rx_busy_i`=0, `retry_ok_o` is 1.
- R2: `retry_ok_o` is 1 exactly when the unit is idle with no loss pending, `normal_i`=1 and `rx_busy_i`=0. A `start_i` pulse while it is 1 raises `drv_en_o` on the next clock edge.
- R3: During the identifier byte, a strobed bit with `tx_bit_i`=1 and `bus_bit_i`=0 clears `drv_en_o` and sets `lost_o` at the next clock edge.
- R4: During the identifier byte, strobed bits that match, or a bit with `tx_bit_i`=0 and `bus_bit_i`=1, leave `drv_en_o` at 1 until the byte boundary.
- R5: The bitwise comparison is off after the identifier byte. A recessive/dominant mismatch inside a data byte does not release the driver before that byte's boundary.
- R6: On a strobe with `byte_end_i`=1, the unit assembles the last 8 strobed bits least significant bit first, for both the transmit and the bus streams. If the two bytes differ during an active frame, `drv_en_o` clears and `lost_o` sets at the next edge.
- R7: A byte boundary with `last_byte_i`=1 and matching bytes ends the frame. `drv_en_o` returns to 0 and `lost_o` stays 0.
- R8: Reception never stops. One cycle after every strobe with `byte_end_i`=1, `rx_vld_o` pulses for one cycle and `rx_byte_o` holds the bus byte (LSB first), whatever the arbitration state.
- R9: `lost_o` stays 1 until IFS_BITS (default 10) consecutive strobes have seen `bus_bit_i`=1, counting only strobes after the loss. A strobe with the bus at 0 restarts the count. `lost_o` clears one cycle after the completing strobe has been registered.
- R10: `start_i` is ignored while `lost_o`=1, `rx_busy_i`=1 or `normal_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| normal_i | input | 1 | Transceiver is in normal (communicating) mode |
| start_i | input | 1 | Request to start a frame |
| rx_busy_i | input | 1 | A reception is in progress |
| tx_bit_i | input | 1 | Bit being transmitted |
| bus_bit_i | input | 1 | Bit sampled back from the bus (0 dominant) |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| byte_end_i | input | 1 | Qualifies a strobe as the last bit of a byte |
| last_byte_i | input | 1 | Qualifies a byte boundary as the end of the frame |
| drv_en_o | output | 1 | Bus driver enable; 0 is high impedance |
| lost_o | output | 1 | Arbitration lost, held until inter-frame space |
| retry_ok_o | output | 1 | A new frame may be started |
| rx_byte_o | output | BYTE_W | Last byte assembled from the bus |
| rx_vld_o | output | 1 | One-cycle pulse when rx_byte_o is updated |

## Verification
The assertions assume single-cycle `bit_stb_i` pulses. They also assume `byte_end_i` and `last_byte_i` are asserted only together with a strobe, and that a byte boundary falls on every eighth strobe. The bench strobes every other cycle and raises the markers only on the eighth bit of each byte. Stimulus covers clean frames, a loss inside the identifier, a mismatch in a data byte, a dominant-read-as-recessive identifier bit, and an idle run that a dominant bit interrupts. It also covers start requests made while busy, while out of normal mode, and while a loss is pending.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PID     = 2'd1,
    ST_DATA    = 2'd2,
    ST_BACKOFF = 2'd3
  } arb_st_e;
endpackage

// File: rtl/arb_bit_cmp.sv
module arb_bit_cmp (
  input  logic en_i,
  input  logic stb_i,
  input  logic tx_bit_i,
  input  logic bus_bit_i,
  output logic loss_o
);
  // recessive sent, dominant read back
  assign loss_o = en_i & stb_i & tx_bit_i & ~bus_bit_i;
endmodule

// File: rtl/arb_byte_cmp.sv
module arb_byte_cmp #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              end_i,
  input  logic              tx_bit_i,
  input  logic              bus_bit_i,
  output logic              mism_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_vld_o
);
  localparam int SR_W = BYTE_W - 1;

  logic [SR_W-1:0]   tx_sr, rx_sr;
  logic [BYTE_W-1:0] tx_full, rx_full;

  assign tx_full = {tx_bit_i, tx_sr};
  assign rx_full = {bus_bit_i, rx_sr};
  assign mism_o  = stb_i & end_i & (tx_full != rx_full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      rx_byte_o <= '0;
      rx_vld_o  <= 1'b0;
    end else begin
      rx_vld_o <= stb_i & end_i;
      if (stb_i) begin
        tx_sr <= tx_full[BYTE_W-1:1];
        rx_sr <= rx_full[BYTE_W-1:1];
        if (end_i) rx_byte_o <= rx_full;
      end
    end
  end

  AST_RX_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && end_i) |=> rx_vld_o); // R8
endmodule

// File: rtl/arb_ifs_det.sv
module arb_ifs_det #(
  parameter int IFS_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic bus_bit_i,
  output logic ifs_o
);
  localparam int CNT_W = $clog2(IFS_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IFS_BITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (stb_i) begin
      if (!bus_bit_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ifs_o = (cnt_q == CNT_MAX);

  AST_IFS_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R9
  AST_IFS_DOM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !bus_bit_i) |=> !ifs_o); // R9
endmodule

// File: rtl/arb_unit.sv
module arb_unit
  import arb_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int IFS_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              normal_i,
  input  logic              start_i,
  input  logic              rx_busy_i,
  input  logic              tx_bit_i,
  input  logic              bus_bit_i,
  input  logic              bit_stb_i,
  input  logic              byte_end_i,
  input  logic              last_byte_i,
  output logic              drv_en_o,
  output logic              lost_o,
  output logic              retry_ok_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_vld_o
);
  arb_st_e st_q, st_d;
  logic    bit_loss, byte_mism, loss, ifs, active, boundary;

  assign active   = (st_q == ST_PID) || (st_q == ST_DATA);
  assign boundary = bit_stb_i & byte_end_i;

  arb_bit_cmp u_bit (
    .en_i     (st_q == ST_PID),
    .stb_i    (bit_stb_i),
    .tx_bit_i (tx_bit_i),
    .bus_bit_i(bus_bit_i),
    .loss_o   (bit_loss)
  );

  arb_byte_cmp #(.BYTE_W(BYTE_W)) u_byte (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (bit_stb_i),
    .end_i    (byte_end_i),
    .tx_bit_i (tx_bit_i),
    .bus_bit_i(bus_bit_i),
    .mism_o   (byte_mism),
    .rx_byte_o(rx_byte_o),
    .rx_vld_o (rx_vld_o)
  );

  assign loss = bit_loss | (active & byte_mism);

  arb_ifs_det #(.IFS_BITS(IFS_BITS)) u_ifs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (loss),
    .stb_i    (bit_stb_i),
    .bus_bit_i(bus_bit_i),
    .ifs_o    (ifs)
  );

  assign retry_ok_o = (st_q == ST_IDLE) & normal_i & ~rx_busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i && retry_ok_o) st_d = ST_PID;
      ST_PID,
      ST_DATA: begin
        if (loss)               st_d = ST_BACKOFF;
        else if (boundary)      st_d = last_byte_i ? ST_IDLE : ST_DATA;
      end
      ST_BACKOFF: if (ifs)      st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign drv_en_o = active;
  assign lost_o   = (st_q == ST_BACKOFF);

  AST_BIT_LOSS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PID && bit_stb_i && tx_bit_i && !bus_bit_i) |=> (!drv_en_o && lost_o)); // R3
  AST_DATA_NO_BITLOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && bit_stb_i && !byte_end_i) |=> drv_en_o); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_en_o && !lost_o && rx_busy_i) |=> !drv_en_o); // R10
  AST_LOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !ifs) |=> lost_o); // R9
  AST_BYTE_MISM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && byte_mism) |=> !drv_en_o); // R6
endmodule

// File: tb/tb_arb_unit.sv
module tb_arb_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IFS_BITS   = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic normal = 1'b1, start = 1'b0, busy = 1'b0;
  logic tx_bit = 1'b1, bus_bit = 1'b1, stb = 1'b0, bend = 1'b0, last = 1'b0;
  logic drv_en, lost, retry_ok, rx_vld;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0;

  arb_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .normal_i(normal), .start_i(start),
    .rx_busy_i(busy), .tx_bit_i(tx_bit), .bus_bit_i(bus_bit), .bit_stb_i(stb),
    .byte_end_i(bend), .last_byte_i(last), .drv_en_o(drv_en), .lost_o(lost),
    .retry_ok_o(retry_ok), .rx_byte_o(rx_byte), .rx_vld_o(rx_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 identifier, 2 data, 3 backoff
  int  m_st = 0, m_idle = 0;
  bit  m_vld = 0;
  int  m_rxb = 0;
  bit  txq[$], rxq[$];

  always @(posedge clk) begin
    if (rst_n) begin
      bit bl, mm, ls, ifs_now;
      int tb_, rb_;
      bl = (m_st == 1) && stb && tx_bit && !bus_bit;
      mm = 0;
      m_vld = 0;
      ifs_now = (m_idle >= IFS_BITS);
      if (stb) begin
        txq.push_back(tx_bit); rxq.push_back(bus_bit);
        if (txq.size() > 8) begin void'(txq.pop_front()); void'(rxq.pop_front()); end
        if (bend) begin
          tb_ = 0; rb_ = 0;
          for (int i = 0; i < txq.size(); i++) begin
            tb_ |= int'(txq[i]) << (i + 8 - txq.size());
            rb_ |= int'(rxq[i]) << (i + 8 - rxq.size());
          end
          m_rxb = rb_; m_vld = 1; mm = (tb_ != rb_);
        end
      end
      ls = bl || ((m_st == 1 || m_st == 2) && mm);
      case (m_st)
        0: if (start && normal && !busy) m_st = 1;
        1, 2: if (ls) m_st = 3; else if (stb && bend) m_st = last ? 0 : 2;
        3: if (ifs_now) m_st = 0;
        default: m_st = 0;
      endcase
      if (ls) m_idle = 0;
      else if (stb) m_idle = bus_bit ? ((m_idle < IFS_BITS) ? m_idle + 1 : IFS_BITS) : 0;
      #(CLK_PERIOD/4);
      chk("R3 drv_en", int'(drv_en), int'(m_st == 1 || m_st == 2));
      chk("R9 lost", int'(lost), int'(m_st == 3));
      chk("R2 retry_ok", int'(retry_ok), int'(m_st == 0 && normal && !busy));
      chk("R8 rx_vld", int'(rx_vld), int'(m_vld));
      if (m_vld) chk("R8 rx_byte", int'(rx_byte), m_rxb);
    end
  end

  task automatic send_bit(input bit t, input bit b, input bit e, input bit l);
    @(negedge clk); tx_bit = t; bus_bit = b; stb = 1; bend = e; last = l;
    @(negedge clk); stb = 0; bend = 0; last = 0; tx_bit = 1; bus_bit = 1;
  endtask

  task automatic send_byte(input logic [7:0] t, input logic [7:0] b, input bit l);
    for (int i = 0; i < 8; i++) send_bit(t[i], b[i], i == 7, l && i == 7);
  endtask

  task automatic req_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 drv_en reset", int'(drv_en), 0);
    chk("R1 lost reset", int'(lost), 0);
    chk("R1 rx_vld reset", int'(rx_vld), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 retry_ok", int'(retry_ok), 1);

    // clean frame
    req_start();
    chk("R2 drv after start", int'(drv_en), 1);
    send_byte(8'h5A, 8'h5A, 0);
    chk("R4 drv after matching id", int'(drv_en), 1);
    send_byte(8'h3C, 8'h3C, 0);
    send_byte(8'h81, 8'h81, 1);
    chk("R7 drv off at end", int'(drv_en), 0);
    chk("R7 not lost", int'(lost), 0);
    chk("R8 last rx byte", int'(rx_byte), 'h81);

    // bitwise loss in identifier at bit 3
    req_start();
    for (int i = 0; i < 3; i++) send_bit(1'(8'h6B >> i), 1'(8'h63 >> i), 0, 0);
    send_bit(1'b1, 1'b0, 0, 0);
    chk("R3 drv released", int'(drv_en), 0);
    chk("R3 lost set", int'(lost), 1);
    for (int i = 4; i < 8; i++) send_bit(1'(8'h6B >> i), 1'(8'h63 >> i), i == 7, 0);
    chk("R8 rx after loss", int'(rx_byte), 'h63);
    req_start();
    chk("R10 start while lost", int'(drv_en), 0);
    idle_bits(IFS_BITS - 1);
    chk("R9 still lost", int'(lost), 1);
    send_bit(1'b1, 1'b0, 0, 0);
    idle_bits(IFS_BITS - 1);
    chk("R9 lost after restart", int'(lost), 1);
    idle_bits(1);
    @(negedge clk);
    chk("R9 lost cleared", int'(lost), 0);
    chk("R9 retry back", int'(retry_ok), 1);

    // start gating
    busy = 1; req_start();
    chk("R10 start while busy", int'(drv_en), 0);
    busy = 0; normal = 0; req_start();
    chk("R10 start not normal", int'(drv_en), 0);
    normal = 1;

    // data byte mismatch
    req_start();
    send_byte(8'h12, 8'h12, 0);
    for (int i = 0; i < 7; i++) send_bit(1'(8'hF0 >> i), 1'(8'hE0 >> i), 0, 0);
    chk("R5 no bitwise release in data", int'(drv_en), 1);
    send_bit(1'b1, 1'b1, 1, 0);
    chk("R6 data mismatch release", int'(drv_en), 0);
    chk("R6 data mismatch lost", int'(lost), 1);
    idle_bits(IFS_BITS); @(negedge clk);

    // identifier bit sent dominant but read recessive
    req_start();
    send_bit(1'b0, 1'b1, 0, 0);
    chk("R4 no bitwise loss on 0/1", int'(drv_en), 1);
    for (int i = 1; i < 8; i++) send_bit(1'(8'h10 >> i), 1'(8'h11 >> i), i == 7, 0);
    chk("R6 id byte mismatch", int'(lost), 1);
    idle_bits(IFS_BITS); @(negedge clk);

    // identifier-only frame after recovery
    req_start();
    send_byte(8'h2D, 8'h2D, 1);
    chk("R7 id only frame done", int'(drv_en), 0);
    chk("R7 id only not lost", int'(lost), 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule